// File: doc/BRIEF.md
# Power Supply Fault Supervisor With Coded Power-Good

This block supervises start-up and protection for a single-phase step-down converter. Comparator results and protection flags reach it already digitized and synchronous to its clock. These cover the supply level against its power-on-reset thresholds, the enable request, two feedback overvoltage levels, the feedback undervoltage level, die over-temperature and a trip pulse from the overcurrent and short-circuit detector. From these it runs a timed soft-start. It grants or withholds the modulator's run permission and latches the faults that must shut the converter down.

Power-good is reported through three pull-down select lines, at most one of them active at any time. The weak line means "starting up" or "undervoltage". The medium line means "overvoltage", and the strong line means "overcurrent or short circuit". With no line active the pin floats high. That state means either "regulating" or "switched off". An overvoltage latch does more than stop switching: it drives the low-side switch as a crowbar with hysteresis between the upper and lower overvoltage levels. Over-temperature pauses switching and latches nothing. Every latched fault clears when enable drops or when the supply falls below its power-on-reset level.

Top module: `psu_fault_supervisor`

## Requirements
- R1: While `sup_en` or `sup_vcc_ok` is low, in that same cycle `pg_sel_weak`, `pg_sel_med`, `pg_sel_strong`, `run_pwm`, `lowside_force` and `ss_busy` are all 0.
- R2: In each operating interval (both `sup_en` and `sup_vcc_ok` high), `ss_busy` is 1 for exactly the first SS_CYCLES cycles. With no fault and no over-temperature, `run_pwm` is 1 throughout.
- R3: With no latched fault, the weak select (`pg_sel_weak`) is 1 for the first PG_CYCLES cycles of operation. After that all three selects are 0, which means power-good is released.
- R4: A cycle with `oc_trip` high latches an overcurrent fault. From the next cycle `pg_sel_strong` is 1 and `run_pwm` is 0, and both stay that way while operation continues.
- R5: A cycle with `fb_ov_hi` high (feedback above 116 %) latches an overvoltage fault. From the next cycle `pg_sel_med` is 1 and `run_pwm` is 0. `lowside_force` goes to 1 one cycle after any cycle with `fb_ov_hi` high. It goes to 0 one cycle after a cycle with `fb_ov_lo` low (feedback below 103 %). Otherwise it keeps its value.
- R6: A cycle with `fb_uv` high (feedback below 84 %) latches an undervoltage fault. It applies only once `ss_busy` is 0. From the next cycle `pg_sel_weak` is 1 and `run_pwm` is 0. `fb_uv` during soft-start has no effect.
- R7: The selects are mutually exclusive. The strong select (overcurrent) outranks the medium select (overvoltage), which outranks the weak select (undervoltage or start-up).
- R8: Leaving operation for at least one clock edge clears all latched faults and the start-up timer. Re-entering operation restarts soft-start with `run_pwm` 1.
- R9: `die_hot` forces `run_pwm` to 0 in the same cycle. It does not change the selects, and it latches nothing, so `run_pwm` returns as soon as `die_hot` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_vcc_ok | input | 1 | Supply above power-on-reset level (hysteresis applied upstream) |
| sup_en | input | 1 | Converter enable request |
| fb_ov_hi | input | 1 | Feedback above upper overvoltage level |
| fb_ov_lo | input | 1 | Feedback above lower overvoltage (crowbar release) level |
| fb_uv | input | 1 | Feedback below undervoltage level |
| die_hot | input | 1 | Die over-temperature, hysteresis applied upstream |
| oc_trip | input | 1 | Overcurrent or short-circuit trip from current detector |
| run_pwm | output | 1 | Permission for the modulator to switch |
| lowside_force | output | 1 | Forces the low-side switch on as an overvoltage crowbar |
| ss_busy | output | 1 | Soft-start interval in progress (drives reference ramp) |
| pg_sel_weak | output | 1 | Weak power-good pull-down select |
| pg_sel_med | output | 1 | Medium power-good pull-down select |
| pg_sel_strong | output | 1 | Strong power-good pull-down select |

## Verification
A start-up counter that is off by some cycles shows up as a `ss_busy` fall or a weak-select release displaced from the cycle that the parameters predict. The bench pins both edges to the exact cycle. A fault latch that loses its value drops its select and brings back `run_pwm` one cycle after the lost state. A wrong priority or encoding shows up at once as the wrong select line. A crowbar with broken hysteresis gives a `lowside_force` value that is wrong one cycle after a threshold crossing, and the bench steps through both threshold levels to expose it.

// File: rtl/psu_sup_pkg.sv
// Package: shared types for the power supply fault supervisor.
// Assumes all users encode the pull-down strength with pg_drive_e.
package psu_sup_pkg;

    // Pull-down strength requested on the power-good pin.
    typedef enum logic [1:0] {
        PG_OPEN   = 2'd0,
        PG_WEAK   = 2'd1,
        PG_MED    = 2'd2,
        PG_STRONG = 2'd3
    } pg_drive_e;

    // Latched fault record.
    typedef struct packed {
        logic oc;
        logic ov;
        logic uv;
    } fault_rec_t;

    localparam int unsigned PG_SEL_W = 3;

endpackage

// File: rtl/psu_startup_timer.sv
// Module: start-up timer. Counts operating cycles from zero and saturates
// at PG_CYCLES. Reports the soft-start window and the power-good release.
// Assumes SS_CYCLES <= PG_CYCLES and that 'active' is synchronous to clk.
module psu_startup_timer #(
    parameter int unsigned SS_CYCLES = 1500,
    parameter int unsigned PG_CYCLES = 2750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic in_softstart,
    output logic pg_ready
);
    localparam int unsigned CNT_W = $clog2(PG_CYCLES + 1);
    localparam logic [CNT_W-1:0] SS_LIM = CNT_W'(SS_CYCLES);
    localparam logic [CNT_W-1:0] PG_LIM = CNT_W'(PG_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: count operating cycles, clear when idle, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (cnt_q != PG_LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: decode the two windows from the count.
    always_comb begin
        in_softstart = active && (cnt_q < SS_LIM);
        pg_ready     = active && (cnt_q == PG_LIM);
    end

    // The counter never passes its limit (R2, R3).
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PG_LIM);

    // The count grows by one per operating cycle until it saturates (R3).
    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && $past(cnt_q) != PG_LIM && $past(rst_n))
            |-> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/psu_fault_latch.sv
// Module: fault latches and overvoltage crowbar. Captures overcurrent,
// overvoltage and (after soft-start) undervoltage while active, and clears
// everything when not active. Crowbar sets on the upper overvoltage level
// and releases below the lower one.
// Assumes the input flags are already synchronous to clk.
module psu_fault_latch
    import psu_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       uv_mask,
    input  logic       oc_in,
    input  logic       ov_hi_in,
    input  logic       ov_lo_in,
    input  logic       uv_in,
    output fault_rec_t faults,
    output logic       crowbar
);
    fault_rec_t flt_q;
    logic       bar_q;

    // Purpose: accumulate faults while active, clear on leaving operation.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            flt_q <= '0;
        end else begin
            flt_q.oc <= flt_q.oc | oc_in;
            flt_q.ov <= flt_q.ov | ov_hi_in;
            flt_q.uv <= flt_q.uv | (uv_in & ~uv_mask);
        end
    end

    // Purpose: hysteretic low-side crowbar between the two overvoltage levels.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bar_q <= 1'b0;
        end else if (ov_hi_in) begin
            bar_q <= 1'b1;
        end else if (!ov_lo_in) begin
            bar_q <= 1'b0;
        end
    end

    assign faults  = flt_q;
    assign crowbar = active & bar_q;

    // An overcurrent record holds while operation continues (R4).
    assert_oc_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flt_q.oc) && $past(active) && active) |-> flt_q.oc);

    // The crowbar is on one cycle after an upper overvoltage sample (R5).
    assert_crowbar_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && $past(ov_hi_in) && $past(rst_n) && active) |-> crowbar);

    // The crowbar never runs without a latched overvoltage (R5).
    assert_crowbar_needs_ov_R5: assert property (@(posedge clk) disable iff (!rst_n)
        crowbar |-> flt_q.ov);

    // Undervoltage sampled inside soft-start leaves no record (R6).
    assert_uv_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && $past(uv_mask) && !$past(flt_q.uv) && $past(rst_n) && active)
            |-> !flt_q.uv);

endmodule

// File: rtl/psu_pg_encoder.sv
// Module: power-good encoder. Picks one pull-down strength by priority
// (overcurrent, then overvoltage, then undervoltage or start-up) and
// expands it to mutually exclusive select lines.
// Assumes sel bit 0 = weak, bit 1 = medium, bit 2 = strong.
module psu_pg_encoder
    import psu_sup_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                pg_ready,
    input  fault_rec_t          faults,
    output logic [PG_SEL_W-1:0] sel
);
    pg_drive_e drive;

    // Purpose: priority choice of the pull-down strength.
    always_comb begin
        if (!active)             drive = PG_OPEN;
        else if (faults.oc)      drive = PG_STRONG;
        else if (faults.ov)      drive = PG_MED;
        else if (faults.uv)      drive = PG_WEAK;
        else if (!pg_ready)      drive = PG_WEAK;
        else                     drive = PG_OPEN;
    end

    // Purpose: one select line per nonzero strength code.
    for (genvar i = 0; i < PG_SEL_W; i++) begin : g_sel
        assign sel[i] = (drive == pg_drive_e'(i + 1));
    end

    // At most one select is active (R7).
    assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // Overcurrent always wins the select (R7).
    assert_oc_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && faults.oc) |-> sel[2]);

endmodule

// File: rtl/psu_fault_supervisor.sv
// Module: top of the power supply fault supervisor. Combines the start-up
// timer, the fault latches and the power-good encoder, and gates the
// modulator run permission.
// Assumes all inputs are synchronous to clk and free of glitches.
module psu_fault_supervisor
    import psu_sup_pkg::*;
#(
    parameter int unsigned SS_CYCLES = 1500,
    parameter int unsigned PG_CYCLES = 2750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_vcc_ok,
    input  logic sup_en,
    input  logic fb_ov_hi,
    input  logic fb_ov_lo,
    input  logic fb_uv,
    input  logic die_hot,
    input  logic oc_trip,
    output logic run_pwm,
    output logic lowside_force,
    output logic ss_busy,
    output logic pg_sel_weak,
    output logic pg_sel_med,
    output logic pg_sel_strong
);
    logic                active;
    logic                in_ss;
    logic                pg_ready;
    fault_rec_t          faults;
    logic                crowbar;
    logic [PG_SEL_W-1:0] sel;

    // Purpose: operating when both enable and the supply are good.
    assign active = sup_en & sup_vcc_ok;

    psu_startup_timer #(
        .SS_CYCLES (SS_CYCLES),
        .PG_CYCLES (PG_CYCLES)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .in_softstart (in_ss),
        .pg_ready     (pg_ready)
    );

    psu_fault_latch u_faults (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .uv_mask  (in_ss),
        .oc_in    (oc_trip),
        .ov_hi_in (fb_ov_hi),
        .ov_lo_in (fb_ov_lo),
        .uv_in    (fb_uv),
        .faults   (faults),
        .crowbar  (crowbar)
    );

    psu_pg_encoder u_pg (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .pg_ready (pg_ready),
        .faults   (faults),
        .sel      (sel)
    );

    // Purpose: run permission, gated at once by enable, supply and heat.
    always_comb begin
        run_pwm = active && !die_hot && (faults == '0);
    end

    assign lowside_force = crowbar;
    assign ss_busy       = in_ss;
    assign pg_sel_weak   = sel[0];
    assign pg_sel_med    = sel[1];
    assign pg_sel_strong = sel[2];

    // Idle converter: nothing driven (R1).
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !(run_pwm || lowside_force || ss_busy || pg_sel_weak
                      || pg_sel_med || pg_sel_strong));

    // Over-temperature blocks switching (R9).
    assert_hot_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        die_hot |-> !run_pwm);

    // A released power-good never coincides with soft-start (R3).
    assert_release_after_ss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !pg_sel_weak && !pg_sel_med && !pg_sel_strong) |-> !ss_busy);

    // Crowbar and switching are never both requested (R5).
    assert_no_run_with_bar_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lowside_force |-> !run_pwm);

endmodule

// File: tb/tb_psu_fault_supervisor.sv
module tb_psu_fault_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int SS_N = 20;
    localparam int PG_N = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_vcc_ok = 1'b0, sup_en = 1'b0;
    logic fb_ov_hi = 1'b0, fb_ov_lo = 1'b0, fb_uv = 1'b0;
    logic die_hot = 1'b0, oc_trip = 1'b0;
    logic run_pwm, lowside_force, ss_busy;
    logic pg_sel_weak, pg_sel_med, pg_sel_strong;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psu_fault_supervisor #(.SS_CYCLES(SS_N), .PG_CYCLES(PG_N)) dut (
        .clk(clk), .rst_n(rst_n), .sup_vcc_ok(sup_vcc_ok), .sup_en(sup_en),
        .fb_ov_hi(fb_ov_hi), .fb_ov_lo(fb_ov_lo), .fb_uv(fb_uv),
        .die_hot(die_hot), .oc_trip(oc_trip), .run_pwm(run_pwm),
        .lowside_force(lowside_force), .ss_busy(ss_busy),
        .pg_sel_weak(pg_sel_weak), .pg_sel_med(pg_sel_med),
        .pg_sel_strong(pg_sel_strong));

    // Advance one edge, then settle away from it.
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Selects packed as {strong, med, weak}.
    function automatic int pg3();
        return {pg_sel_strong, pg_sel_med, pg_sel_weak};
    endfunction

    task automatic clear_inputs();
        fb_ov_hi = 0; fb_ov_lo = 0; fb_uv = 0; die_hot = 0; oc_trip = 0;
    endtask

    // Bring the converter up and wait until power-good is released.
    task automatic bring_up();
        clear_inputs();
        sup_en = 0; tick();
        sup_vcc_ok = 1; sup_en = 1;
        tick(PG_N);
    endtask

    task automatic t_reset();
        chk("R1", "selects at reset", pg3(), 0);
        chk("R1", "run_pwm at reset", run_pwm, 0);
        chk("R1", "lowside_force at reset", lowside_force, 0);
    endtask

    task automatic t_softstart();
        clear_inputs();
        sup_vcc_ok = 1; sup_en = 0; tick();
        chk("R1", "selects with enable low", pg3(), 0);
        sup_en = 1; #1;
        chk("R2", "ss_busy first cycle", ss_busy, 1);
        chk("R2", "run_pwm in soft-start", run_pwm, 1);
        chk("R3", "weak select at start", pg3(), 1);
        tick(SS_N - 1);
        chk("R2", "ss_busy last soft-start cycle", ss_busy, 1);
        tick();
        chk("R2", "ss_busy after SS_CYCLES", ss_busy, 0);
        chk("R3", "still weak after soft-start", pg3(), 1);
        tick(PG_N - SS_N - 1);
        chk("R3", "weak one cycle before release", pg3(), 1);
        tick();
        chk("R3", "released at PG_CYCLES", pg3(), 0);
        chk("R2", "run_pwm regulating", run_pwm, 1);
    endtask

    task automatic t_uv_masked();
        clear_inputs(); sup_en = 0; tick();
        sup_en = 1; fb_uv = 1;
        tick(SS_N);
        fb_uv = 0;
        chk("R6", "uv in soft-start ignored, run_pwm", run_pwm, 1);
        tick(PG_N - SS_N);
        chk("R6", "uv in soft-start ignored, release", pg3(), 0);
    endtask

    task automatic t_uv_fault();
        bring_up();
        fb_uv = 1; tick(); fb_uv = 0;
        chk("R6", "uv fault select weak", pg3(), 1);
        chk("R6", "uv fault run_pwm", run_pwm, 0);
        tick(3);
        chk("R6", "uv fault latched", pg3(), 1);
    endtask

    task automatic t_oc();
        bring_up();
        oc_trip = 1; #1;
        chk("R4", "run_pwm same cycle as trip", run_pwm, 1);
        tick(); oc_trip = 0;
        chk("R4", "oc select strong", pg3(), 4);
        chk("R4", "oc run_pwm", run_pwm, 0);
        tick(5);
        chk("R4", "oc latched", pg3(), 4);
    endtask

    task automatic t_ov_crowbar();
        bring_up();
        fb_ov_hi = 1; fb_ov_lo = 1; tick();
        chk("R5", "ov select medium", pg3(), 2);
        chk("R5", "crowbar on", lowside_force, 1);
        chk("R5", "ov run_pwm", run_pwm, 0);
        fb_ov_hi = 0; tick();
        chk("R5", "crowbar holds between levels", lowside_force, 1);
        fb_ov_lo = 0; tick();
        chk("R5", "crowbar off below low level", lowside_force, 0);
        fb_ov_lo = 1; tick();
        chk("R5", "crowbar stays off below high level", lowside_force, 0);
        chk("R5", "ov still latched", pg3(), 2);
        fb_ov_hi = 1; tick();
        chk("R5", "crowbar on again", lowside_force, 1);
        sup_en = 0; #1;
        chk("R1", "crowbar off when disabled", lowside_force, 0);
        chk("R1", "selects open when disabled", pg3(), 0);
        tick(); clear_inputs();
        sup_en = 1; #1;
        chk("R8", "fault cleared by enable, weak", pg3(), 1);
        chk("R8", "run_pwm after re-enable", run_pwm, 1);
        chk("R8", "soft-start restarts", ss_busy, 1);
    endtask

    task automatic t_priority();
        bring_up();
        fb_uv = 1; fb_ov_hi = 1; fb_ov_lo = 1; tick();
        chk("R7", "ov outranks uv", pg3(), 2);
        oc_trip = 1; tick();
        chk("R7", "oc outranks ov", pg3(), 4);
        clear_inputs(); tick();
        chk("R7", "oc kept", pg3(), 4);
    endtask

    task automatic t_por_drop();
        bring_up();
        oc_trip = 1; tick(); oc_trip = 0;
        sup_vcc_ok = 0; #1;
        chk("R1", "run_pwm off with supply low", run_pwm, 0);
        chk("R1", "selects open with supply low", pg3(), 0);
        tick();
        sup_vcc_ok = 1; #1;
        chk("R8", "supply return clears oc", pg3(), 1);
        chk("R8", "supply return run_pwm", run_pwm, 1);
    endtask

    task automatic t_hot();
        bring_up();
        die_hot = 1; #1;
        chk("R9", "hot stops run_pwm at once", run_pwm, 0);
        chk("R9", "hot leaves selects", pg3(), 0);
        tick(3);
        chk("R9", "hot no latch on selects", pg3(), 0);
        die_hot = 0; #1;
        chk("R9", "run_pwm resumes", run_pwm, 1);
        sup_en = 0; #1;
        chk("R1", "enable low stops run_pwm at once", run_pwm, 0);
        chk("R1", "ss_busy idle", ss_busy, 0);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1; tick();
        t_softstart();
        t_uv_masked();
        t_uv_fault();
        t_oc();
        t_ov_crowbar();
        t_priority();
        t_por_drop();
        t_hot();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule